// File: doc/BRIEF.md
# Condition Code Register Update Unit

This block keeps the eight status and mask bits of a small 8-bit processor and works out their next value on every clock. The execution stage tells it which class of operation retired, together with the result word, the carry and overflow from the ALU, and the low nibbles of the two addends. From these it updates the arithmetic flags. It also handles register loads from the accumulator-transfer path and from the return-from-interrupt restore path.

The two interrupt mask bits follow rules that are not the same in both directions. The maskable-interrupt mask is set by reset or by any interrupt acknowledge, and software may clear it. The non-maskable-line mask can only be set by hardware, through reset or an acknowledge on that line. Software can only clear it. A software write that carries a one in that bit position leaves the mask as it was. The stacking sequencer pulses an acknowledge strobe once the registers are stacked. The mask change is registered at that edge, so it is visible before the vector fetch. Two combinational enable outputs feed the interrupt arbiter. Requests that are blocked are held by the arbiter and are never dropped here.

Top module: `ccr_unit`

## Requirements
- R1: Bit 7 down to bit 0 of `ccr` hold S, X, H, I, N, Z, V, C. An active-low reset, applied asynchronously, loads 8'hD0, which sets S, X and I and clears the rest.
- R2: `irq_enable` is the inverse of I and `xirq_enable` is the inverse of X, both combinational from the register.
- R3: X goes from 0 to 1 only by reset or by `xirq_ack`. No software write ever sets it.
- R4: A software write clears X only when bit 6 of the written byte is 0. With bit 6 at 1, X keeps its old value.
- R5: `irq_ack` sets I at the next edge. `xirq_ack` sets both I and X at the next edge.
- R6: Operation class 3'd5 (index increment/decrement) sets Z when the full 16-bit result is zero and clears it otherwise, leaving every other bit unchanged.
- R7: Operation class 3'd1 (add, add-accumulators, add-with-carry) loads H with the carry out of `nib_a + nib_b + nib_cin`. N takes result bit 7, Z is set when result bits 7:0 are zero, and V and C take `alu_v` and `alu_c`.
- R8: Operation class 3'd2 (subtract and compare) updates N, Z, V and C as class 3'd1 does, and leaves H unchanged.
- R9: Operation class 3'd3 (logic and data move) updates N and Z from the 8-bit result and clears V. C and H are left unchanged.
- R10: Operation class 3'd4 (16-bit arithmetic) takes N from result bit 15 and Z from all 16 bits being zero. V and C take the ALU inputs and H is unchanged.
- R11: Operation classes 3'd0, 3'd6 and 3'd7 leave the register unchanged.
- R12: A software write loads S, H, I, N, Z, V and C straight from the written byte. A restore write (`rti_we`) takes precedence over an accumulator transfer (`tap_we`). Any software write replaces the flag update of the operation class in that cycle.
- R13: Reset overrides everything. An acknowledge forces its mask bits to 1 even when a software write in the same cycle would clear them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 3 | Class of the retiring operation |
| result | input | 16 | ALU result (8-bit operations use bits 7:0) |
| alu_c | input | 1 | ALU carry/borrow out |
| alu_v | input | 1 | ALU two's-complement overflow |
| nib_a | input | 4 | Low nibble of the first addend |
| nib_b | input | 4 | Low nibble of the second addend |
| nib_cin | input | 1 | Carry into bit 0 of the addition |
| tap_we | input | 1 | Load from accumulator A |
| tap_data | input | 8 | Byte from accumulator A |
| rti_we | input | 1 | Restore from stack on return from interrupt |
| rti_data | input | 8 | Byte popped from the stack |
| irq_ack | input | 1 | Maskable interrupt acknowledged, stacking complete |
| xirq_ack | input | 1 | Non-maskable-line interrupt acknowledged, stacking complete |
| ccr | output | 8 | Condition code register |
| irq_enable | output | 1 | Maskable interrupts allowed |
| xirq_enable | output | 1 | Non-maskable-line interrupts allowed |

## Verification
The properties assume that the acknowledge strobes are single pulses. They also assume that the nibble inputs of an add-class operation belong to the same addition as its result and carries, and that the ALU inputs are don't-care in cycles whose class does not use them. The bench keeps to these assumptions. It gives every table vector its own preset byte, written through the accumulator path, and it drives the strobes for one cycle at a time. The only vectors that put an acknowledge, a software write and an operation in the same cycle are directed ones, and their expected bytes are worked out from the stated priority.

// File: rtl/ccr_unit.sv
module ccr_unit #(
  parameter int RES_W = 16,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_class,
  input  logic [RES_W-1:0] result,
  input  logic             alu_c,
  input  logic             alu_v,
  input  logic [NIB_W-1:0] nib_a,
  input  logic [NIB_W-1:0] nib_b,
  input  logic             nib_cin,
  input  logic             tap_we,
  input  logic [7:0]       tap_data,
  input  logic             rti_we,
  input  logic [7:0]       rti_data,
  input  logic             irq_ack,
  input  logic             xirq_ack,
  output logic [7:0]       ccr,
  output logic             irq_enable,
  output logic             xirq_enable
);
  localparam int B_S = 7, B_X = 6, B_H = 5, B_I = 4;
  localparam int B_N = 3, B_Z = 2, B_V = 1, B_C = 0;
  localparam logic [7:0] RST_VAL = 8'hD0;

  localparam logic [2:0] OP_ADD = 3'd1, OP_SUB = 3'd2, OP_LOG = 3'd3;
  localparam logic [2:0] OP_WIDE = 3'd4, OP_IDX = 3'd5;

  logic [NIB_W:0] nib_sum;
  logic           z8, z16;
  logic [7:0]     sw_byte, nxt;

  assign nib_sum = {1'b0, nib_a} + {1'b0, nib_b} + {{NIB_W{1'b0}}, nib_cin};
  assign z8      = (result[7:0] == 8'h00);
  assign z16     = (result == '0);
  assign sw_byte = rti_we ? rti_data : tap_data;

  always_comb begin
    nxt = ccr;
    case (op_class)
      OP_ADD: begin
        nxt[B_H] = nib_sum[NIB_W];
        nxt[B_N] = result[7];
        nxt[B_Z] = z8;
        nxt[B_V] = alu_v;
        nxt[B_C] = alu_c;
      end
      OP_SUB: begin
        nxt[B_N] = result[7];
        nxt[B_Z] = z8;
        nxt[B_V] = alu_v;
        nxt[B_C] = alu_c;
      end
      OP_LOG: begin
        nxt[B_N] = result[7];
        nxt[B_Z] = z8;
        nxt[B_V] = 1'b0;
      end
      OP_WIDE: begin
        nxt[B_N] = result[RES_W-1];
        nxt[B_Z] = z16;
        nxt[B_V] = alu_v;
        nxt[B_C] = alu_c;
      end
      OP_IDX:  nxt[B_Z] = z16;
      default: ;
    endcase
    if (rti_we || tap_we) begin
      nxt      = sw_byte;
      nxt[B_X] = ccr[B_X] & sw_byte[B_X];
    end
    if (irq_ack || xirq_ack) nxt[B_I] = 1'b1;
    if (xirq_ack)            nxt[B_X] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccr <= RST_VAL;
    else        ccr <= nxt;
  end

  assign irq_enable  = ~ccr[B_I];
  assign xirq_enable = ~ccr[B_X];

  logic unused_s;
  assign unused_s = ccr[B_S];
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op_class,
  input logic [3:0]  nib_a,
  input logic [3:0]  nib_b,
  input logic        nib_cin,
  input logic        tap_we,
  input logic [7:0]  tap_data,
  input logic        rti_we,
  input logic [7:0]  rti_data,
  input logic        irq_ack,
  input logic        xirq_ack,
  input logic [7:0]  ccr
);
  logic [4:0] half_sum;
  logic       sw, ack, x_clear_req;
  assign half_sum    = {1'b0, nib_a} + {1'b0, nib_b} + {4'b0, nib_cin};
  assign sw          = tap_we || rti_we;
  assign ack         = irq_ack || xirq_ack;
  assign x_clear_req = sw && !(rti_we ? rti_data[6] : tap_data[6]) && !xirq_ack;

  p_x_set_hw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccr[6]) |-> $past(xirq_ack));

  p_x_clear_sw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ccr[6]) |-> $past(x_clear_req));

  p_ack_sets_i_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ccr[4]);

  p_xack_sets_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xirq_ack |=> ccr[6]);

  p_idx_only_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 3'd5 && !sw && !ack) |=>
      (ccr[7:3] == $past(ccr[7:3]) && ccr[1:0] == $past(ccr[1:0])));

  p_half_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 3'd1 && !sw) |=> ccr[5] == $past(half_sum[4]));

  p_hold_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_class == 3'd0 || op_class >= 3'd6) && !sw && !ack) |=> $stable(ccr));
endmodule

bind ccr_unit ccr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_class(op_class),
  .nib_a(nib_a), .nib_b(nib_b), .nib_cin(nib_cin),
  .tap_we(tap_we), .tap_data(tap_data),
  .rti_we(rti_we), .rti_data(rti_data),
  .irq_ack(irq_ack), .xirq_ack(xirq_ack), .ccr(ccr)
);

// File: tb/ccr_unit_tb_top.sv
`timescale 1ns/1ps
module ccr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_class = '0;
  logic [15:0] result = '0;
  logic        alu_c = 1'b0, alu_v = 1'b0;
  logic [3:0]  nib_a = '0, nib_b = '0;
  logic        nib_cin = 1'b0;
  logic        tap_we = 1'b0, rti_we = 1'b0;
  logic [7:0]  tap_data = '0, rti_data = '0;
  logic        irq_ack = 1'b0, xirq_ack = 1'b0;
  logic [7:0]  ccr;
  logic        irq_enable, xirq_enable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ccr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .result(result),
    .alu_c(alu_c), .alu_v(alu_v), .nib_a(nib_a), .nib_b(nib_b),
    .nib_cin(nib_cin), .tap_we(tap_we), .tap_data(tap_data),
    .rti_we(rti_we), .rti_data(rti_data), .irq_ack(irq_ack),
    .xirq_ack(xirq_ack), .ccr(ccr), .irq_enable(irq_enable),
    .xirq_enable(xirq_enable)
  );

  // {pre, op, result, nib_a, nib_b, nib_cin, alu_c, alu_v, expected}
  localparam int NV = 19;
  localparam logic [45:0] VEC [0:NV-1] = '{
    {8'h00, 3'd1, 16'h0000, 4'h8, 4'h8, 1'b0, 1'b1, 1'b0, 8'h25},
    {8'h20, 3'd1, 16'h007F, 4'h3, 4'h4, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h00, 3'd1, 16'h0080, 4'hF, 4'h0, 1'b1, 1'b0, 1'b1, 8'h2A},
    {8'h00, 3'd1, 16'h000F, 4'h7, 4'h8, 1'b0, 1'b1, 1'b0, 8'h01},
    {8'h00, 3'd1, 16'h0010, 4'h7, 4'h8, 1'b1, 1'b0, 1'b0, 8'h20},
    {8'h00, 3'd1, 16'h00FF, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 8'h29},
    {8'h20, 3'd2, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h25},
    {8'h00, 3'd2, 16'h00FE, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h0A},
    {8'h03, 3'd3, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h05},
    {8'h02, 3'd3, 16'h0091, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 8'h08},
    {8'h00, 3'd4, 16'h0100, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h00, 3'd4, 16'h8000, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h09},
    {8'h00, 3'd4, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'h06},
    {8'hAB, 3'd5, 16'h0000, 4'hF, 4'hF, 1'b1, 1'b1, 1'b1, 8'hAF},
    {8'h2F, 3'd5, 16'h0001, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h2B},
    {8'h9B, 3'd5, 16'h0100, 4'h8, 4'h8, 1'b0, 1'b0, 1'b0, 8'h9B},
    {8'h3C, 3'd0, 16'h0000, 4'h8, 4'h8, 1'b1, 1'b1, 1'b1, 8'h3C},
    {8'hA5, 3'd6, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 8'hA5},
    {8'h12, 3'd7, 16'hFFFF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h12}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    tap_we = 1'b0; rti_we = 1'b0; irq_ack = 1'b0; xirq_ack = 1'b0;
    op_class = 3'd0;
  endtask

  task automatic tap(input logic [7:0] d);
    tap_we = 1'b1; tap_data = d;
    tick();
  endtask

  task automatic rti(input logic [7:0] d);
    rti_we = 1'b1; rti_data = d;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", ccr, 8'hD0);
    check("R2 enables in reset", {6'b0, irq_enable, xirq_enable}, 8'h00);
    rst_n = 1'b1;
    tick();
    check("R1 value held after release", ccr, 8'hD0);

    tap(8'hFF);
    check("R4 tap with bit6 set keeps X", ccr, 8'hFF);
    tap(8'h00);
    check("R4 tap with bit6 clear clears X", ccr, 8'h00);
    check("R2 enables follow masks", {6'b0, irq_enable, xirq_enable}, 8'h03);
    tap(8'h40);
    check("R3 tap cannot set X", ccr, 8'h00);
    rti(8'h7F);
    check("R3 restore cannot set X", ccr, 8'h3F);
    check("R2 irq_enable low with I set", {7'b0, irq_enable}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      tap(VEC[i][45:38]);
      op_class = VEC[i][37:35];
      result   = VEC[i][34:19];
      nib_a    = VEC[i][18:15];
      nib_b    = VEC[i][14:11];
      nib_cin  = VEC[i][10];
      alu_c    = VEC[i][9];
      alu_v    = VEC[i][8];
      tick();
      case (VEC[i][37:35])
        3'd1:    check($sformatf("R7 add vector %0d", i), ccr, VEC[i][7:0]);
        3'd2:    check($sformatf("R8 sub vector %0d", i), ccr, VEC[i][7:0]);
        3'd3:    check($sformatf("R9 logic vector %0d", i), ccr, VEC[i][7:0]);
        3'd4:    check($sformatf("R10 wide vector %0d", i), ccr, VEC[i][7:0]);
        3'd5:    check($sformatf("R6 index vector %0d", i), ccr, VEC[i][7:0]);
        default: check($sformatf("R11 hold vector %0d", i), ccr, VEC[i][7:0]);
      endcase
    end

    // both write paths in one cycle: the restore byte wins
    tap(8'h00);
    tap_we = 1'b1; tap_data = 8'h0F; rti_we = 1'b1; rti_data = 8'h83;
    tick();
    check("R12 restore beats transfer", ccr, 8'h83);
    // a software write overrides the operation update
    tap_we = 1'b1; tap_data = 8'h01;
    op_class = 3'd1; result = 16'h0000; nib_a = 4'h8; nib_b = 4'h8; alu_c = 1'b0;
    tick();
    check("R12 write overrides add", ccr, 8'h01);

    tap(8'h00);
    irq_ack = 1'b1;
    tick();
    check("R5 irq_ack sets I", ccr, 8'h10);
    tap(8'h00);
    xirq_ack = 1'b1;
    tick();
    check("R5 xirq_ack sets X and I", ccr, 8'h50);
    check("R3 xirq_enable low after acknowledge", {7'b0, xirq_enable}, 8'h00);
    rti(8'h00);
    check("R4 restore clears X after acknowledge", ccr, 8'h00);

    tap_we = 1'b1; tap_data = 8'h0F; irq_ack = 1'b1;
    tick();
    check("R13 ack beats write clearing I", ccr, 8'h1F);
    tap(8'h00);
    rti_we = 1'b1; rti_data = 8'h00; xirq_ack = 1'b1;
    tick();
    check("R13 xirq_ack beats restore", ccr, 8'h50);
    rti(8'h00);
    irq_ack = 1'b1; op_class = 3'd1; result = 16'h0000;
    nib_a = 4'h8; nib_b = 4'h8; nib_cin = 1'b0; alu_c = 1'b1; alu_v = 1'b0;
    tick();
    check("R5 ack merges with add update", ccr, 8'h35);

    tap_we = 1'b1; tap_data = 8'h00; irq_ack = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    check("R13 reset beats ack and write", ccr, 8'hD0);
    tap_we = 1'b0; irq_ack = 1'b0;
    rst_n = 1'b1;
    tick();
    check("R1 value after second reset", ccr, 8'hD0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule